// File: doc/BRIEF.md
# Averaging Grid Enable Sequencer

This block drives the horizontal and vertical interconnect-enable lines of a pixel array. In that array, neighbouring pixel storage nodes can be tied together so that their charge equalizes over rectangular regions. For each grid step the block produces one enable pattern. A line is high inside a rectangle and low where it sits on a boundary between two rectangles. Each new step merges 2×2 rectangles of the previous grid, so the rectangle side doubles from step to step.

A frame starts with a pulse on `frame_start_i`. The block first requests a readout of the captured image with a side of 1, and all lines are low during that readout. After each `rdout_done_i` it applies the next grid and requests another readout. Because averaging overwrites the previous picture, every grid waits for the readout of the one before it. The readout address step equals the reported side, since one pixel per rectangle is enough. The first frame after reset uses sides 4, 8, 16 and so on. The next frame uses 6, 12, 24 and so on, and the two progressions keep alternating frame by frame. A frame ends after `MAX_STEPS` grids, or earlier when the next side would exceed the smaller array dimension.

Top module: `avg_grid_sequencer`

## Requirements
- R1: After reset, all column and row enables are 0, `rdout_req_o` is 0 and `side_o` is 1.
- R2: A `frame_start_i` pulse sampled while idle gives a one-cycle `rdout_req_o` on the next cycle, with `side_o` = 1 and every enable line 0 (capture readout).
- R3: Column line k (bit k, between columns k and k+1) and row line k (bit k, between rows k and k+1) are 0 exactly when (k+1) is a multiple of `side_o`. There are WIDTH-1 column lines and HEIGHT-1 row lines.
- R4: The first grid of a frame has side 4 in even frames and side 6 in odd frames. The first frame after reset is even.
- R5: Each `rdout_done_i` accepted while waiting after a grid doubles the side and raises `rdout_req_o`. The side and the enables hold steady until `rdout_done_i` arrives.
- R6: The frame ends after the readout of grid number `MAX_STEPS`, or when the doubled side would exceed min(WIDTH, HEIGHT). The block then returns to idle with all enables 0 and `side_o` = 1.
- R7: A `frame_start_i` that arrives while a frame is in progress is ignored. It neither adds a readout nor changes the progression of the next frame.
- R8: A `rdout_done_i` that arrives while idle is ignored.
- R9: `rdout_req_o` is high for exactly one cycle per readout request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start_i | input | 1 | Start-of-frame pulse |
| rdout_done_i | input | 1 | Readout of the current configuration finished |
| col_en_o | output | WIDTH-1 | Column interconnect enables, bit k between columns k and k+1 |
| row_en_o | output | HEIGHT-1 | Row interconnect enables, bit k between rows k and k+1 |
| rdout_req_o | output | 1 | One-cycle readout request strobe |
| side_o | output | $clog2(min(WIDTH,HEIGHT))+2 | Current rectangle side, which is also the readout address step |

## Verification
The single-cycle strobe property assumes that `rdout_done_i` is never high in the same cycle as `rdout_req_o`, because a readout cannot finish the moment it is requested. The stimulus therefore always raises the done pulse two or more cycles after it sees the strobe. The hold property for side and enables assumes that done arrives only as a single-cycle pulse. The bench keeps done to one cycle, and it injects the stray start and done pulses only when the block is in the phase where they must be ignored.

// File: rtl/grid_seq_pkg.sv
package grid_seq_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } seq_state_e;

    // first rectangle side of each progression
    localparam int BASE_EVEN = 4;
    localparam int BASE_ODD  = 6;
endpackage

// File: rtl/grid_step_ctrl.sv
module grid_step_ctrl
    import grid_seq_pkg::*;
#(
    parameter int DMIN      = 36,
    parameter int MAX_STEPS = 4,
    parameter int SIDE_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start_i,
    input  logic              rdout_done_i,
    output logic [SIDE_W-1:0] side_o,
    output logic              req_o,
    output logic              busy_o
);
    localparam int STEP_W = $clog2(MAX_STEPS + 1) + 1;
    localparam logic [SIDE_W-1:0] DMIN_S = SIDE_W'(DMIN);
    localparam logic [STEP_W-1:0] MAX_S  = STEP_W'(MAX_STEPS);
    localparam logic [SIDE_W-1:0] B_EVEN = SIDE_W'(BASE_EVEN);
    localparam logic [SIDE_W-1:0] B_ODD  = SIDE_W'(BASE_ODD);

    typedef struct packed {
        seq_state_e        st;
        logic [SIDE_W-1:0] side;
        logic [STEP_W-1:0] step;
        logic              par;   // parity of the next frame
        logic              prog;  // progression of the current frame
        logic              req;
    } ctrl_t;

    ctrl_t q, d;
    logic [SIDE_W-1:0] nxt_side;

    always_comb begin
        d        = q;
        d.req    = 1'b0;
        nxt_side = (q.step == '0) ? (q.prog ? B_ODD : B_EVEN) : (q.side << 1);
        case (q.st)
            ST_IDLE: begin
                if (frame_start_i) begin
                    d.st   = ST_WAIT;
                    d.side = SIDE_W'(1);
                    d.step = '0;
                    d.prog = q.par;
                    d.par  = ~q.par;
                    d.req  = 1'b1;
                end
            end
            default: begin
                if (rdout_done_i) begin
                    if (q.step == MAX_S || nxt_side > DMIN_S) begin
                        d.st   = ST_IDLE;
                        d.side = SIDE_W'(1);
                        d.step = '0;
                    end else begin
                        d.side = nxt_side;
                        d.step = q.step + STEP_W'(1);
                        d.req  = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, side: SIDE_W'(1), step: '0, par: 1'b0, prog: 1'b0, req: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign side_o = q.side;
    assign req_o  = q.req;
    assign busy_o = (q.st == ST_WAIT);

    // R9
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> !req_o);
    // R5
    side_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !rdout_done_i) |=> $stable(side_o));
    // R6
    side_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (side_o <= DMIN_S) && (side_o != '0));
    // R6
    step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.step <= MAX_S);
    // R7
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && frame_start_i) |=> $stable(q.par));
    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !frame_start_i) |=> (!req_o && !busy_o));
endmodule

// File: rtl/boundary_mask.sv
module boundary_mask #(
    parameter int LINES  = 39,
    parameter int SIDE_W = 8
) (
    input  logic [SIDE_W-1:0] side_i,
    output logic [LINES-1:0]  en_o
);
    logic [31:0] side_ext;
    assign side_ext = {{(32 - SIDE_W){1'b0}}, side_i};

    for (genvar k = 0; k < LINES; k++) begin : g_line
        localparam logic [31:0] POS = 32'(k + 1);
        assign en_o[k] = (side_ext == 32'd0) ? 1'b0 : ((POS % side_ext) != 32'd0);
    end

    always_comb begin
        if (side_ext != 32'd0) begin
            // R3
            low_count_chk: assert ($countones(~en_o) == (LINES / int'(side_ext)));
        end
    end
endmodule

// File: rtl/avg_grid_sequencer.sv
module avg_grid_sequencer #(
    parameter int WIDTH     = 40,
    parameter int HEIGHT    = 36,
    parameter int MAX_STEPS = 4
) (
    input  logic                                               clk,
    input  logic                                               rst_n,
    input  logic                                               frame_start_i,
    input  logic                                               rdout_done_i,
    output logic [WIDTH-2:0]                                   col_en_o,
    output logic [HEIGHT-2:0]                                  row_en_o,
    output logic                                               rdout_req_o,
    output logic [$clog2((WIDTH < HEIGHT) ? WIDTH : HEIGHT)+1:0] side_o
);
    localparam int DMIN   = (WIDTH < HEIGHT) ? WIDTH : HEIGHT;
    localparam int SIDE_W = $clog2(DMIN) + 2;

    logic busy;

    grid_step_ctrl #(
        .DMIN(DMIN), .MAX_STEPS(MAX_STEPS), .SIDE_W(SIDE_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .frame_start_i(frame_start_i), .rdout_done_i(rdout_done_i),
        .side_o(side_o), .req_o(rdout_req_o), .busy_o(busy)
    );

    boundary_mask #(.LINES(WIDTH - 1), .SIDE_W(SIDE_W)) u_col (
        .side_i(side_o), .en_o(col_en_o)
    );

    boundary_mask #(.LINES(HEIGHT - 1), .SIDE_W(SIDE_W)) u_row (
        .side_i(side_o), .en_o(row_en_o)
    );

    // R6
    idle_lines_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (col_en_o == '0 && row_en_o == '0));
endmodule

// File: tb/sim_avg_grid_sequencer.sv
module sim_avg_grid_sequencer;
    localparam int W = 40, H = 36, MS = 4, DMIN = 36, SW = 8;

    logic clk = 0, rst_n = 0, fs = 0, dn = 0;
    logic [W-2:0] col0, col1;
    logic [H-2:0] row0, row1;
    logic req0, req1;
    logic [SW-1:0] side0, side1;

    avg_grid_sequencer #(.WIDTH(W), .HEIGHT(H), .MAX_STEPS(MS)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_start_i(fs), .rdout_done_i(dn),
        .col_en_o(col0), .row_en_o(row0), .rdout_req_o(req0), .side_o(side0));
    avg_grid_sequencer #(.WIDTH(W), .HEIGHT(H), .MAX_STEPS(2)) u1 (
        .clk(clk), .rst_n(rst_n), .frame_start_i(fs), .rdout_done_i(dn),
        .col_en_o(col1), .row_en_o(row1), .rdout_req_o(req1), .side_o(side1));

    always #4 clk = ~clk;

    int checks = 0, errors = 0, u1_reqs = 0;
    bit finished = 0;
    int exp_q[$];

    function automatic logic [W-2:0] col_mask(int side);
        logic [W-2:0] m;
        for (int k = 0; k < W - 1; k++) m[k] = ((k + 1) % side) != 0;
        return m;
    endfunction
    function automatic logic [H-2:0] row_mask(int side);
        logic [H-2:0] m;
        for (int k = 0; k < H - 1; k++) m[k] = ((k + 1) % side) != 0;
        return m;
    endfunction

    task automatic check(bit ok, string rq, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // monitor: every strobe pops one expected side
    always @(negedge clk) begin
        if (rst_n && req0) begin
            if (exp_q.size() == 0) begin
                check(0, "R7", "unexpected readout strobe", 1, 0);
            end else begin
                int s;
                s = exp_q.pop_front();
                check(side0 == SW'(s), "R5", "side at strobe", side0, s);
                check(col0 == col_mask(s), "R3", "column enables", col0, col_mask(s));
                check(row0 == row_mask(s), "R3", "row enables", row0, row_mask(s));
            end
        end
        if (rst_n && req1) u1_reqs++;
    end

    task automatic run_frame(input bit odd, input bit inject);
        int sides[$];
        int s, n;
        sides.push_back(1);
        s = odd ? 6 : 4;
        n = 0;
        while (n < MS && s <= DMIN) begin
            sides.push_back(s);
            s = s * 2;
            n++;
        end
        foreach (sides[i]) exp_q.push_back(sides[i]);
        u1_reqs = 0;
        @(negedge clk) fs = 1;
        @(negedge clk) fs = 0;
        for (int i = 0; i < sides.size(); i++) begin
            int t = 0;
            while (!req0 && t < 40) begin
                @(negedge clk);
                t++;
            end
            if (i == 0) check(req0 && side0 == 1, "R2", "capture strobe", side0, 1);
            if (i == 1) check(side0 == SW'(odd ? 6 : 4), "R4", "first grid side", side0, odd ? 6 : 4);
            @(negedge clk);
            check(req0 == 0, "R9", "strobe width", req0, 0);
            check(side0 == SW'(sides[i]), "R5", "side held before done", side0, sides[i]);
            if (inject && i == 0) begin
                fs = 1;
                @(negedge clk) fs = 0;
            end
            @(negedge clk) dn = 1;
            @(negedge clk) dn = 0;
        end
        repeat (3) @(negedge clk);
        check(side0 == 1, "R6", "side after frame", side0, 1);
        check(col0 == '0 && row0 == '0, "R6", "enables after frame", col0, 0);
        check(exp_q.size() == 0, "R6", "readouts left", exp_q.size(), 0);
        check(u1_reqs == 3, "R6", "step-limited readouts", u1_reqs, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(side0 == 1 && req0 == 0, "R1", "reset side/strobe", side0, 1);
        check(col0 == '0 && row0 == '0, "R1", "reset enables", col0, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        run_frame(0, 0);
        run_frame(1, 0);
        // R8: done while idle
        @(negedge clk) dn = 1;
        @(negedge clk) dn = 0;
        repeat (4) @(negedge clk);
        check(side0 == 1 && col0 == '0, "R8", "idle after stray done", side0, 1);
        run_frame(0, 1);
        run_frame(1, 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule